// File: doc/BRIEF.md
# Pin Output and Direction Register Bank with Atomic Aliases

This block keeps the drive value and the drive direction of a bank of general purpose pins, and returns the live pin levels to software. Each of the two registers, the output value and the output enable, sits behind four write addresses. One address loads the whole register. The other three apply the written word as a mask: they set the masked bits, clear them, or invert them. Bits outside the mask keep their values.

Because the update is resolved inside the register, two agents that own different pins can change them without a read-modify-write sequence, and neither can overwrite the other's bits. Reads return registered data one clock after the address is presented. An asynchronous active-low reset is applied at once and released in step with the clock. The reset leaves every pin undriven, so every pin starts as an input.

Top module: `gpio_alias_regs`

## Requirements
- R1: While reset is held and after it is released, before any write, `pin_out`, `pin_oe` and `bus_rdata` are all zero.
- R2: A write with `bus_we`=1 to address 1 loads `wdata[29:0]` into the output register. The new value appears on `pin_out` after the next rising clock edge.
- R3: A write to address 2 drives to 1 every output bit whose `wdata` bit is 1. The other output bits are unchanged.
- R4: A write to address 3 drives to 0 every output bit whose `wdata` bit is 1. The other output bits are unchanged.
- R5: A write to address 4 inverts every output bit whose `wdata` bit is 1. The other output bits are unchanged.
- R6: The output enable register (`pin_oe`, 1 = drive, 0 = input) is loaded at address 5 and is set, cleared and toggled at addresses 6, 7 and 8, with the same per-bit rules as R2 to R5.
- R7: When address 0 is presented, `bus_rdata[29:0]` equals the `pin_in` value sampled at the next rising edge. The value is valid after that edge.
- R8: Presenting address 1 or address 5 returns the output register or the enable register, as they held before that edge. All other addresses read 0, and `bus_rdata[31:30]` is always 0.
- R9: Bits 31 and 30 of `bus_wdata` have no effect on any register.
- R10: With `bus_we`=0 no register changes. A write to an output address never changes `pin_oe`, and a write to an enable address never changes `pin_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | 4 | Word address for read and write |
| bus_wdata | input | 32 | Write data or mask |
| bus_we | input | 1 | Write strobe, one write per cycle it is high |
| bus_rdata | output | 32 | Registered read data |
| pin_in | input | 30 | Pin levels from the pads |
| pin_out | output | 30 | Pin drive values |
| pin_oe | output | 30 | Pin drive enables |

## Verification
The properties assume that the bus writes only after the internal reset has been released. Under that assumption, the value on `bus_addr` and `bus_wdata` in the cycle the strobe is high fully defines the register update. The bench holds reset for several cycles and waits for the internal release before it issues its first write. It changes every input only on the falling clock edge, so each write and each read address is stable around the rising edge that samples it. Random addresses cover the whole 4-bit space, including unmapped and read-only words. Random data sets bits 31 and 30 about half the time.

// File: rtl/gpio_alias_pkg.sv
package gpio_alias_pkg;
  // Per-bit update applied by an alias write
  typedef enum logic [1:0] {
    OP_LOAD = 2'd0,
    OP_SET  = 2'd1,
    OP_CLR  = 2'd2,
    OP_TGL  = 2'd3
  } alias_op_e;

  localparam int unsigned ADDR_IN      = 0;
  localparam int unsigned ADDR_OUT     = 1;  // first of four output aliases
  localparam int unsigned ADDR_OE      = 5;  // first of four enable aliases
  localparam int unsigned ALIAS_SPAN   = 4;
  localparam int unsigned NUM_BANKS    = 2;
endpackage

// File: rtl/gpio_rst_sync.sv
module gpio_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_core_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_core_n = chain_q[STAGES-1];
endmodule

// File: rtl/gpio_alias_reg.sv
module gpio_alias_reg
  import gpio_alias_pkg::*;
#(
  parameter int unsigned WIDTH = 30
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  alias_op_e        op,
  input  logic [WIDTH-1:0] mask,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] reg_q;
  logic [WIDTH-1:0] reg_d;

  always_comb begin
    unique case (op)
      OP_LOAD: reg_d = mask;
      OP_SET:  reg_d = reg_q | mask;
      OP_CLR:  reg_d = reg_q & ~mask;
      OP_TGL:  reg_d = reg_q ^ mask;
      default: reg_d = reg_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     reg_q <= '0;
    else if (wr_en) reg_q <= reg_d;
  end

  assign q = reg_q;
endmodule

// File: rtl/gpio_read_port.sv
module gpio_read_port
  import gpio_alias_pkg::*;
#(
  parameter int unsigned NUM_PINS = 30,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned ADDR_W   = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [NUM_PINS-1:0] pin_in,
  input  logic [NUM_PINS-1:0] out_q,
  input  logic [NUM_PINS-1:0] oe_q,
  output logic [DATA_W-1:0]   rdata
);
  logic [DATA_W-1:0] rdata_q;
  logic [DATA_W-1:0] rdata_d;

  always_comb begin
    if (addr == ADDR_W'(ADDR_IN))       rdata_d = DATA_W'(pin_in);
    else if (addr == ADDR_W'(ADDR_OUT)) rdata_d = DATA_W'(out_q);
    else if (addr == ADDR_W'(ADDR_OE))  rdata_d = DATA_W'(oe_q);
    else                                rdata_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata_q <= '0;
    else        rdata_q <= rdata_d;
  end

  assign rdata = rdata_q;
endmodule

// File: rtl/gpio_alias_regs.sv
module gpio_alias_regs
  import gpio_alias_pkg::*;
#(
  parameter int unsigned NUM_PINS    = 30,
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned ADDR_W      = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [DATA_W-1:0]   bus_wdata,
  input  logic                bus_we,
  output logic [DATA_W-1:0]   bus_rdata,
  input  logic [NUM_PINS-1:0] pin_in,
  output logic [NUM_PINS-1:0] pin_out,
  output logic [NUM_PINS-1:0] pin_oe
);
  localparam int unsigned HI_W = DATA_W - NUM_PINS;

  logic                rst_core_n;
  logic [NUM_PINS-1:0] bank_q [NUM_BANKS];
  logic                unused_wdata_hi;

  // bits above the pin count are never stored
  assign unused_wdata_hi = ^bus_wdata[DATA_W-1:NUM_PINS];

  gpio_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_core_n (rst_core_n)
  );

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    localparam int unsigned BASE = (g == 0) ? ADDR_OUT : ADDR_OE;
    logic [ADDR_W-1:0] offs;
    logic              hit;
    alias_op_e         op;

    always_comb begin
      offs = bus_addr - ADDR_W'(BASE);
      hit  = bus_we && (offs < ADDR_W'(ALIAS_SPAN));
      op   = alias_op_e'(offs[1:0]);
    end

    gpio_alias_reg #(.WIDTH(NUM_PINS)) u_reg (
      .clk   (clk),
      .rst_n (rst_core_n),
      .wr_en (hit),
      .op    (op),
      .mask  (bus_wdata[NUM_PINS-1:0]),
      .q     (bank_q[g])
    );
  end

  gpio_read_port #(
    .NUM_PINS (NUM_PINS),
    .DATA_W   (DATA_W),
    .ADDR_W   (ADDR_W)
  ) u_rd (
    .clk    (clk),
    .rst_n  (rst_core_n),
    .addr   (bus_addr),
    .pin_in (pin_in),
    .out_q  (bank_q[0]),
    .oe_q   (bank_q[1]),
    .rdata  (bus_rdata)
  );

  assign pin_out = bank_q[0];
  assign pin_oe  = bank_q[1];

  if (HI_W == 0) begin : g_no_hi
  end
endmodule

// File: rtl/gpio_alias_checker.sv
module gpio_alias_checker
  import gpio_alias_pkg::*;
#(
  parameter int unsigned NUM_PINS = 30,
  parameter int unsigned ADDR_W   = 4,
  parameter int unsigned HI_W     = 2
) (
  input logic                clk,
  input logic                rst_core_n,
  input logic [ADDR_W-1:0]   bus_addr,
  input logic [NUM_PINS-1:0] mask,
  input logic                bus_we,
  input logic [HI_W-1:0]     rd_hi,
  input logic [NUM_PINS-1:0] pin_out,
  input logic [NUM_PINS-1:0] pin_oe
);
  a_r2_out_load: assert property (@(posedge clk) disable iff (!rst_core_n)
    (bus_we && bus_addr == ADDR_W'(ADDR_OUT)) |=> pin_out == $past(mask));

  a_r3_out_set: assert property (@(posedge clk) disable iff (!rst_core_n)
    (bus_we && bus_addr == ADDR_W'(ADDR_OUT + 1)) |=>
      ((pin_out & $past(mask)) == $past(mask)) &&
      ((pin_out & ~$past(mask)) == ($past(pin_out) & ~$past(mask))));

  a_r4_out_clr: assert property (@(posedge clk) disable iff (!rst_core_n)
    (bus_we && bus_addr == ADDR_W'(ADDR_OUT + 2)) |=>
      ((pin_out & $past(mask)) == '0) &&
      ((pin_out & ~$past(mask)) == ($past(pin_out) & ~$past(mask))));

  a_r5_out_tgl: assert property (@(posedge clk) disable iff (!rst_core_n)
    (bus_we && bus_addr == ADDR_W'(ADDR_OUT + 3)) |=>
      pin_out == ($past(pin_out) ^ $past(mask)));

  a_r6_oe_tgl: assert property (@(posedge clk) disable iff (!rst_core_n)
    (bus_we && bus_addr == ADDR_W'(ADDR_OE + 3)) |=>
      pin_oe == ($past(pin_oe) ^ $past(mask)));

  a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_core_n)
    !bus_we |=> $stable(pin_out) && $stable(pin_oe));

  a_r8_rdata_hi_zero: assert property (@(posedge clk) disable iff (!rst_core_n)
    rd_hi == '0);
endmodule

bind gpio_alias_regs gpio_alias_checker #(
  .NUM_PINS (NUM_PINS),
  .ADDR_W   (ADDR_W),
  .HI_W     (DATA_W - NUM_PINS)
) u_chk (
  .clk        (clk),
  .rst_core_n (rst_core_n),
  .bus_addr   (bus_addr),
  .mask       (bus_wdata[NUM_PINS-1:0]),
  .bus_we     (bus_we),
  .rd_hi      (bus_rdata[DATA_W-1:NUM_PINS]),
  .pin_out    (pin_out),
  .pin_oe     (pin_oe)
);

// File: tb/gpio_alias_regs_tb_top.sv
`timescale 1ns/1ps
module gpio_alias_regs_tb_top;
  logic        clk;
  logic        rst_n;
  logic [3:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic        bus_we;
  logic [31:0] bus_rdata;
  logic [29:0] pin_in;
  logic [29:0] pin_out;
  logic [29:0] pin_oe;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [29:0] m_out;
  logic [29:0] m_oe;

  gpio_alias_regs dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_we    (bus_we),
    .bus_rdata (bus_rdata),
    .pin_in    (pin_in),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [29:0] upd(logic [29:0] cur, int base,
                                      logic [3:0] a, logic [31:0] w, logic e);
    int off;
    off = int'(a) - base;
    if (!e || off < 0 || off > 3) return cur;
    case (off)
      0: return w[29:0];
      1: return cur | w[29:0];
      2: return cur & ~w[29:0];
      default: return cur ^ w[29:0];
    endcase
  endfunction

  function automatic logic [31:0] rd_exp(logic [3:0] a, logic [29:0] pin,
                                         logic [29:0] o, logic [29:0] oe);
    case (a)
      4'd0: return {2'b00, pin};
      4'd1: return {2'b00, o};
      4'd5: return {2'b00, oe};
      default: return 32'd0;
    endcase
  endfunction

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic step(logic [3:0] a, logic [31:0] w, logic e, logic [29:0] p, string tag);
    logic [29:0] n_out, n_oe;
    logic [31:0] n_rd;
    n_out = upd(m_out, 1, a, w, e);
    n_oe  = upd(m_oe, 5, a, w, e);
    n_rd  = rd_exp(a, p, m_out, m_oe);
    bus_addr = a; bus_wdata = w; bus_we = e; pin_in = p;
    @(posedge clk);
    @(negedge clk);
    bus_we = 1'b0;
    m_out = n_out;
    m_oe  = n_oe;
    check(tag, "pin_out", {2'b00, pin_out}, {2'b00, m_out});
    check(tag, "pin_oe", {2'b00, pin_oe}, {2'b00, m_oe});
    check(tag, "rdata", bus_rdata, n_rd);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 1'b0; bus_addr = '0; bus_wdata = '0; bus_we = 1'b0; pin_in = '0;
    m_out = '0; m_oe = '0;
    repeat (3) @(negedge clk);
    check("R1", "pin_out in reset", {2'b00, pin_out}, 32'd0);
    check("R1", "pin_oe in reset", {2'b00, pin_oe}, 32'd0);
    check("R1", "rdata in reset", bus_rdata, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1", "pin_out after release", {2'b00, pin_out}, 32'd0);
    check("R1", "pin_oe after release", {2'b00, pin_oe}, 32'd0);

    // directed corners
    step(4'd1, 32'hFFFF_FFFF, 1'b1, 30'h0, "R9");
    step(4'd1, 32'h0, 1'b0, 30'h0, "R8");
    step(4'd3, 32'h0000_FFFF, 1'b1, 30'h0, "R4");
    step(4'd2, 32'hC000_0001, 1'b1, 30'h0, "R3");
    step(4'd4, 32'h3FFF_FFFF, 1'b1, 30'h0, "R5");
    step(4'd6, 32'h2AAA_AAAA, 1'b1, 30'h0, "R6");
    step(4'd7, 32'h0000_000A, 1'b1, 30'h0, "R6");
    step(4'd8, 32'hFFFF_FFFF, 1'b1, 30'h0, "R6");
    step(4'd5, 32'h0, 1'b0, 30'h1234_567, "R8");
    step(4'd2, 32'h3FFF_FFFF, 1'b0, 30'h0, "R10");
    step(4'd0, 32'h0, 1'b0, 30'h2BAD_F00D & 30'h3FFF_FFFF, "R7");
    step(4'd12, 32'hFFFF_FFFF, 1'b1, 30'h3FFF_FFFF, "R8");
    step(4'd5, 32'h1555_5555, 1'b1, 30'h0, "R6");
    step(4'd1, 32'h0F0F_0F0F, 1'b1, 30'h0, "R2");
    step(4'd1, 32'h0, 1'b0, 30'h0, "R10");

    // random traffic
    for (int i = 0; i < 400; i++) begin
      logic [3:0]  a;
      logic [31:0] w;
      logic        e;
      logic [29:0] p;
      string       tag;
      a = 4'($urandom_range(0, 15));
      w = $urandom();
      e = 1'($urandom_range(0, 1));
      p = 30'($urandom());
      case (a)
        4'd0: tag = "R7";
        4'd1: tag = "R2";
        4'd2: tag = "R3";
        4'd3: tag = "R4";
        4'd4: tag = "R5";
        4'd5, 4'd6, 4'd7, 4'd8: tag = "R6";
        default: tag = "R8";
      endcase
      if (!e) tag = "R10";
      step(a, w, e, p, tag);
    end

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule